// File: doc/BRIEF.md
# Port-Enable Control Register Bank

This block is the control and status register bank of a serial service-interface master. A host reaches it over a simple word-organised bus. The bus has a read strobe, a write strobe, a byte address, 32-bit write data and 32-bit registered read data. The bank holds two 32-bit port-enable masks: a low mask for ports 0 to 31 and a high mask for ports 32 to 63.

Software can load a mask directly. It can also change a mask through a set alias, which ORs the data in, or through a clear alias, which removes every bit that is 1 in the data. A fixed version word can be read. A reset-status word always reads zero, meaning no errors. A soft-reset command word returns the whole bank to its defaults. Every other in-range word is ordinary read/write storage.

The word index is the byte address divided by four, and the two low address bits are ignored. The bank has 128 words (byte offsets 0x000 to 0x1FC). Accesses beyond the last word have no effect.

Top module: `svc_ctl_regs`

## Requirements
- R1: A write to byte offset 0x010 loads the low enable mask with the data unchanged, and a write to 0x014 does the same for the high mask. Each mask reads back at its own offset.
- R2: A write to 0x018 ORs the data into the low mask, and a write to 0x01C ORs it into the high mask. Bits that are 0 in the data keep their previous value.
- R3: A write to 0x020 clears in the low mask every bit that is 1 in the data, and a write to 0x024 does the same for the high mask. Bits that are 0 in the data keep their previous value.
- R4: The word at 0x074 reads 0xE0050101 from reset onward. Writes to it have no effect.
- R5: The word at 0x0D0 always reads zero. Writes to it have no effect.
- R6: A write to 0x1D0 with data bit 31 or data bit 30 set returns every word to its reset value: both masks and all storage become zero, and the version word keeps its value. This happens at the clock edge that captures the write. A write to 0x1D0 with both bits clear changes nothing, and the word at 0x1D0 reads zero.
- R7: An access whose word index (byte address shifted right by two) is 128 or more is ignored. Such a read returns zero, and such a write changes no in-range word.
- R8: A write to any other in-range offset stores the data in that word, which then reads it back. The alias offsets 0x018 to 0x024 store nothing of their own and read zero.
- R9: Read data appears on the clock edge that captures the read strobe and holds until the next read. Address bits 1 and 0 are ignored. After reset the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | AW (12) | Byte address |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Registered read data |

## Verification
The bench loads both masks with mixed patterns and then drives set and clear data that overlap the stored bits only in part. A design that overwrote the mask through an alias, or inverted the wrong operand, would show wrong bits in the untouched half.

Out-of-range writes go to 0x200, the address that wraps onto word 0 when the index is truncated. A design that dropped the range check would corrupt word 0.

Soft-reset commands are sent with neither, one or the other of bits 30 and 31 set. A design that ignored the error-reset bit would keep its state. A design that reset on any write to 0x1D0 would wipe the masks. A design that reset the version word would lose 0xE0050101.

Writes to the version and status words test that they cannot be overwritten. Reads at misaligned addresses, and idle cycles after a read, show whether the low address bits are decoded and whether read data drifts between reads.

// File: rtl/svc_ctl_pkg.sv
package svc_ctl_pkg;

    // word indices (byte offset >> 2)
    localparam int IDX_EN_LO    = 4;   // 0x010
    localparam int IDX_EN_HI    = 5;   // 0x014
    localparam int IDX_SET_LO   = 6;   // 0x018
    localparam int IDX_SET_HI   = 7;   // 0x01C
    localparam int IDX_CLR_LO   = 8;   // 0x020
    localparam int IDX_CLR_HI   = 9;   // 0x024
    localparam int IDX_VERSION  = 29;  // 0x074
    localparam int IDX_STATUS   = 52;  // 0x0D0
    localparam int IDX_SOFTRST  = 116; // 0x1D0

    localparam int GEN_RST_BIT  = 31;
    localparam int ERR_RST_BIT  = 30;

    localparam int NUM_MASKS    = 2;

    typedef struct packed {
        logic                 in_range;
        logic                 wr_plain;
        logic [NUM_MASKS-1:0] wr_direct;
        logic [NUM_MASKS-1:0] wr_set;
        logic [NUM_MASKS-1:0] wr_clear;
        logic                 soft_rst;
    } hit_t;

endpackage

// File: rtl/svc_ctl_decode.sv
module svc_ctl_decode
    import svc_ctl_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DW     = 32,
    parameter int NWORDS = 128,
    localparam int IW    = AW - 2,
    localparam int LW    = $clog2(NWORDS)
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output hit_t          hit,
    output logic [LW-1:0] widx
);

    logic [IW-1:0] idx_full;
    logic          special;

    always_comb begin
        idx_full = addr[AW-1:2];
        widx     = idx_full[LW-1:0];
        hit      = '0;
        hit.in_range = ({1'b0, idx_full} < (IW+1)'(NWORDS));

        special = (widx == LW'(IDX_EN_LO))  || (widx == LW'(IDX_EN_HI))  ||
                  (widx == LW'(IDX_SET_LO)) || (widx == LW'(IDX_SET_HI)) ||
                  (widx == LW'(IDX_CLR_LO)) || (widx == LW'(IDX_CLR_HI)) ||
                  (widx == LW'(IDX_VERSION)) || (widx == LW'(IDX_STATUS)) ||
                  (widx == LW'(IDX_SOFTRST));

        if (wr_en && hit.in_range) begin
            hit.wr_plain     = !special;
            hit.wr_direct[0] = (widx == LW'(IDX_EN_LO));
            hit.wr_direct[1] = (widx == LW'(IDX_EN_HI));
            hit.wr_set[0]    = (widx == LW'(IDX_SET_LO));
            hit.wr_set[1]    = (widx == LW'(IDX_SET_HI));
            hit.wr_clear[0]  = (widx == LW'(IDX_CLR_LO));
            hit.wr_clear[1]  = (widx == LW'(IDX_CLR_HI));
            hit.soft_rst     = (widx == LW'(IDX_SOFTRST)) &&
                               (wdata[GEN_RST_BIT] || wdata[ERR_RST_BIT]);
        end
    end

endmodule

// File: rtl/svc_ctl_portmask.sv
module svc_ctl_portmask #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_direct,
    input  logic          wr_set,
    input  logic          wr_clear,
    input  logic          soft_rst,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask
);

    typedef struct packed {
        logic [DW-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (soft_rst)
            state_d.mask = '0;
        else if (wr_direct)
            state_d.mask = wdata;
        else if (wr_set)
            state_d.mask = state_q.mask | wdata;
        else if (wr_clear)
            state_d.mask = state_q.mask & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign mask = state_q.mask;

    assert_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_direct && !soft_rst) |=> (mask == $past(wdata)));

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !soft_rst && !wr_direct) |=>
            (((mask & $past(wdata)) == $past(wdata)) &&
             ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !soft_rst && !wr_direct && !wr_set) |=>
            (((mask & $past(wdata)) == '0) &&
             ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))));

endmodule

// File: rtl/svc_ctl_store.sv
module svc_ctl_store #(
    parameter int DW     = 32,
    parameter int NWORDS = 128,
    localparam int LW    = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          soft_rst,
    input  logic [LW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] ridx,
    output logic [DW-1:0] rword
);

    typedef struct packed {
        logic [NWORDS-1:0][DW-1:0] words;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (soft_rst)
            state_d.words = '0;
        else if (wr_en)
            state_d.words[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rword = state_q.words[ridx];

    assert_plain_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (state_q.words[$past(widx)] == $past(wdata)));

    assert_store_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state_q.words == '0));

endmodule

// File: rtl/svc_ctl_regs.sv
module svc_ctl_regs
    import svc_ctl_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          DW      = 32,
    parameter int          NWORDS  = 128,
    parameter logic [31:0] VERSION = 32'hE005_0101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int LW = $clog2(NWORDS);

    hit_t          hit;
    logic [LW-1:0] widx;
    logic [DW-1:0] en_val [NUM_MASKS];
    logic [DW-1:0] store_word;
    logic [DW-1:0] rd_mux;

    svc_ctl_decode #(.AW(AW), .DW(DW), .NWORDS(NWORDS)) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .hit   (hit),
        .widx  (widx)
    );

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
        svc_ctl_portmask #(.DW(DW)) u_mask (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_direct (hit.wr_direct[g]),
            .wr_set    (hit.wr_set[g]),
            .wr_clear  (hit.wr_clear[g]),
            .soft_rst  (hit.soft_rst),
            .wdata     (wdata),
            .mask      (en_val[g])
        );
    end

    svc_ctl_store #(.DW(DW), .NWORDS(NWORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hit.wr_plain),
        .soft_rst (hit.soft_rst),
        .widx     (widx),
        .wdata    (wdata),
        .ridx     (widx),
        .rword    (store_word)
    );

    // read port: two-process
    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        if (!hit.in_range)
            rd_mux = '0;
        else if (widx == LW'(IDX_EN_LO))
            rd_mux = en_val[0];
        else if (widx == LW'(IDX_EN_HI))
            rd_mux = en_val[1];
        else if (widx == LW'(IDX_VERSION))
            rd_mux = DW'(VERSION);
        else
            rd_mux = store_word;

        rd_d = rd_q;
        if (rd_en)
            rd_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign rdata = rd_q.rdata;

    assert_version_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit.in_range && widx == LW'(IDX_VERSION)) |=> (rdata == DW'(VERSION)));

    assert_status_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit.in_range && widx == LW'(IDX_STATUS)) |=> (rdata == '0));

    assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit.soft_rst |=> ((en_val[0] == '0) && (en_val[1] == '0)));

    assert_range_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit.in_range) |=> (rdata == '0));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/svc_ctl_regs_test.sv
module svc_ctl_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int NW = 128;
    localparam logic [31:0] VER = 32'hE005_0101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_ctl_regs uut (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    function automatic logic [31:0] expect_read(logic [AW-1:0] a);
        int idx = int'(a >> 2);
        if (idx >= NW) return 32'h0;
        if (idx == 29) return VER;
        return model[idx];
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        int idx = int'(a >> 2);
        if (idx >= NW) return "R7";
        case (idx)
            4, 5:   return "R1";
            29:     return "R4";
            52:     return "R5";
            116:    return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NW; i++) model[i] = 32'h0;
    endtask

    task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
        int idx = int'(a >> 2);
        if (idx >= NW) return;
        case (idx)
            4, 5:   model[idx] = d;
            6, 7:   model[idx-2] = model[idx-2] | d;
            8, 9:   model[idx-4] = model[idx-4] & ~d;
            29, 52: ;
            116:    if (d[31] || d[30]) model_reset();
            default: model[idx] = d;
        endcase
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [AW-1:0] a, string tag);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp = expect_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R9: reset value of read data
        check("R9", rdata, 32'h0);
        rst_n = 1'b1;

        do_read(12'h074, "R4");
        do_read(12'h010, "R1");
        // R1 direct loads
        do_write(12'h010, 32'hA5A5_0F0F);
        do_write(12'h014, 32'h1234_5678);
        do_read(12'h010, "R1");
        do_read(12'h014, "R1");
        // R2 set aliases
        do_write(12'h018, 32'h0000_F0F0);
        do_read(12'h010, "R2");
        do_write(12'h01C, 32'h8000_0001);
        do_read(12'h014, "R2");
        // R3 clear aliases
        do_write(12'h020, 32'hFFFF_0000);
        do_read(12'h010, "R3");
        do_write(12'h024, 32'h1200_0000);
        do_read(12'h014, "R3");
        // R8 alias reads zero
        do_read(12'h018, "R8");
        do_read(12'h024, "R8");
        // R4 version is write-protected
        do_write(12'h074, 32'hDEAD_BEEF);
        do_read(12'h074, "R4");
        // R5 status
        do_write(12'h0D0, 32'hFFFF_FFFF);
        do_read(12'h0D0, "R5");
        // R8 plain storage, first and last
        do_write(12'h000, 32'h0BAD_F00D);
        do_write(12'h1FC, 32'hCAFE_0001);
        do_read(12'h000, "R8");
        do_read(12'h1FC, "R8");
        // R7 out-of-range write must not wrap onto word 0
        do_write(12'h200, 32'h1111_2222);
        do_read(12'h200, "R7");
        do_read(12'h000, "R7");
        do_read(12'hFFC, "R7");
        // R9 low address bits ignored, read data holds
        do_read(12'h013, "R9");
        held = rdata;
        repeat (4) @(negedge clk);
        check("R9", rdata, held);
        // R6 soft reset: no-op data, then each reset bit
        do_write(12'h1D0, 32'h2FFF_FFFF);
        do_read(12'h010, "R6");
        do_read(12'h1D0, "R6");
        do_write(12'h1D0, 32'h4000_0000);
        do_read(12'h010, "R6");
        do_read(12'h1FC, "R6");
        do_read(12'h074, "R6");
        do_write(12'h014, 32'h0F0F_0F0F);
        do_write(12'h1D0, 32'h8000_0000);
        do_read(12'h014, "R6");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int sel = int'($urandom_range(0, 15));
            int idx;
            logic [AW-1:0] a;
            case (sel)
                0, 1:  idx = 4 + int'($urandom_range(0, 5));
                2:     idx = 29;
                3:     idx = 52;
                4:     idx = ($urandom_range(0, 31) == 0) ? 116 : 4;
                5:     idx = 128 + int'($urandom_range(0, 895));
                6, 7:  idx = 4 + int'($urandom_range(0, 1));
                default: idx = int'($urandom_range(0, 127));
            endcase
            if (idx == 116 && $urandom_range(0, 3) != 0) idx = 5;
            a = {idx[AW-3:0], 2'($urandom_range(0, 3))};
            if ($urandom_range(0, 1) == 1)
                do_write(a, $urandom());
            else
                do_read(a, tag_of(a));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule